// File: doc/BRIEF.md
# Hex Value Character Display Writer

This block shows a 32-bit binary value as eight hexadecimal characters on a pair of four-character dot-matrix display modules. Each module keeps the characters it has been given in its own memory and accepts one character at a time over a shared 7-bit ASCII code bus and a shared 2-bit position bus. A separate active-low write strobe selects the module that takes the character.

A client presents a value and pulses an update request. The block captures the value and turns each nibble into the ASCII code of its hexadecimal digit. It then writes the eight characters one after another with fixed setup, strobe and hold timing, steering each strobe to the module that owns the position. When the last character has been written it raises a one-cycle done pulse. Because the modules retain their contents, the value is written once per update and never refreshed.

If a request arrives while a sequence is running, it is remembered and a fresh sequence starts right after the current one. That sequence uses the most recent value that was requested.

Top module: `hexdisp_writer`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy` and `done` are 0 and every bit of `disp_wr_n` is 1.
- R2: A nibble n in 0..9 is written as ASCII code 0x30+n, and a nibble in 10..15 is written as 0x41+(n-10) (upper-case A to F). No other code is ever strobed.
- R3: Character k (k = 0..7) carries nibble bits [31-4k : 28-4k] of the captured value, so the most significant nibble goes first. It is written to module k/4 (bit k/4 of `disp_wr_n`) at position k mod 4, where position 0 is the leftmost. Once a sequence completes, the two modules together hold the hex string of the value.
- R4: Each character takes four cycles. In the first, position and code are driven and no strobe is active. In the second and third, only the target module's strobe is low. In the fourth, all strobes are high. Position and code stay constant through all four cycles, and at most one strobe is low at any time.
- R5: A request sampled while idle is accepted. From the next cycle, `busy` is 1 for exactly 32 cycles while the characters are written in order 0 to 7.
- R6: A request sampled while busy does not disturb the running sequence. A second sequence starts in the cycle right after the last hold cycle, with `busy` staying 1. It uses the value of the latest request sampled before then, and several such requests yield only one extra sequence.
- R7: `done` is 1 for exactly one cycle: the cycle after the last hold cycle of each sequence.
- R8: Changes on `upd_value` with no request sampled have no effect: no strobe is issued and the stored characters stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| upd_req | input | 1 | Update request, sampled each rising edge |
| upd_value | input | 32 | Value to display, taken with `upd_req` |
| busy | output | 1 | A write sequence is in progress |
| done | output | 1 | One-cycle pulse after the last character |
| disp_wr_n | output | 2 | Active-low write strobe, one bit per module |
| disp_addr | output | 2 | Character position within the module, 0 = leftmost |
| disp_char | output | 7 | ASCII code of the character being written |

## Verification
The bench builds the block with its default parameters: two modules of four characters, a 32-bit value, and a 1/2/1-cycle setup/strobe/hold split. This makes the whole 32-cycle sequence and the boundary between modules 0 and 1 visible within a few dozen cycles. The chosen values cover every digit from 0 to F, and include all-ones and all-zeros. Further cases are a request that lands exactly on the final hold cycle, several queued requests, and value changes with no request. The bench models both modules as four-entry character memories that load on the rising edge of their strobe, and reads back the stored string after each sequence.

// File: rtl/hexdisp_pkg.sv
`timescale 1ns/1ps
package hexdisp_pkg;

  // Phase of one character write
  typedef enum logic [1:0] {
    PH_SETUP  = 2'd0,
    PH_STROBE = 2'd1,
    PH_HOLD   = 2'd2
  } wr_phase_e;

  // Hex digit to upper-case ASCII
  function automatic logic [6:0] nib_to_ascii(input logic [3:0] n);
    if (n < 4'd10) return 7'h30 + {3'b000, n};
    else           return 7'h37 + {3'b000, n};
  endfunction

endpackage

// File: rtl/hexdisp_req_latch.sv
`timescale 1ns/1ps
module hexdisp_req_latch #(
  parameter int VALUE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd_req,
  input  logic [VALUE_W-1:0] upd_value,
  input  logic               active,
  input  logic               seq_end,
  output logic               start,
  output logic [VALUE_W-1:0] start_value
);

  logic               pend_q;
  logic [VALUE_W-1:0] pend_val_q;

  // A start happens on an idle request, or at the end of a sequence
  // when either a fresh request or a remembered one exists.
  always_comb begin
    start       = (upd_req && (!active || seq_end)) || (pend_q && seq_end);
    start_value = upd_req ? upd_value : pend_val_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      pend_val_q <= '0;
    end else if (seq_end) begin
      pend_q     <= 1'b0;
    end else if (upd_req && active) begin
      pend_q     <= 1'b1;
      pend_val_q <= upd_value;
    end
  end

endmodule

// File: rtl/hexdisp_sequencer.sv
`timescale 1ns/1ps
module hexdisp_sequencer
  import hexdisp_pkg::*;
#(
  parameter int NUM_CHARS  = 8,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1,
  parameter int IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             active,
  output logic             seq_end,
  output logic             nxt_active,
  output logic [IDX_W-1:0] nxt_idx,
  output wr_phase_e        nxt_phase
);

  localparam int MAX_A   = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_DUR = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int TICK_W  = (MAX_DUR > 1) ? $clog2(MAX_DUR) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CHARS - 1);

  logic              active_q;
  logic [IDX_W-1:0]  idx_q;
  wr_phase_e         phase_q;
  logic [TICK_W-1:0] tick_q;
  logic [TICK_W-1:0] tick_d;
  logic [TICK_W-1:0] dur_m1;
  logic              phase_done;

  always_comb begin
    case (phase_q)
      PH_SETUP:  dur_m1 = TICK_W'(SETUP_CYC - 1);
      PH_STROBE: dur_m1 = TICK_W'(STROBE_CYC - 1);
      default:   dur_m1 = TICK_W'(HOLD_CYC - 1);
    endcase
  end

  assign phase_done = (tick_q == dur_m1);
  assign seq_end    = active_q && (phase_q == PH_HOLD) && phase_done && (idx_q == LAST_IDX);
  assign active     = active_q;

  always_comb begin
    nxt_active = active_q;
    nxt_idx    = idx_q;
    nxt_phase  = phase_q;
    tick_d     = tick_q;
    if (start) begin
      nxt_active = 1'b1;
      nxt_idx    = '0;
      nxt_phase  = PH_SETUP;
      tick_d     = '0;
    end else if (active_q) begin
      if (!phase_done) begin
        tick_d = tick_q + 1'b1;
      end else begin
        tick_d = '0;
        case (phase_q)
          PH_SETUP:  nxt_phase = PH_STROBE;
          PH_STROBE: nxt_phase = PH_HOLD;
          default: begin
            nxt_phase = PH_SETUP;
            if (idx_q == LAST_IDX) nxt_active = 1'b0;
            else                   nxt_idx    = idx_q + 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      phase_q  <= PH_SETUP;
      tick_q   <= '0;
    end else begin
      active_q <= nxt_active;
      idx_q    <= nxt_idx;
      phase_q  <= nxt_phase;
      tick_q   <= tick_d;
    end
  end

endmodule

// File: rtl/hexdisp_outreg.sv
`timescale 1ns/1ps
module hexdisp_outreg
  import hexdisp_pkg::*;
#(
  parameter int NUM_MODS       = 2,
  parameter int DIGITS_PER_MOD = 4,
  parameter int IDX_W          = 3,
  parameter int ADDR_W         = 2,
  parameter int VALUE_W        = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [VALUE_W-1:0] start_value,
  input  logic               nxt_active,
  input  logic [IDX_W-1:0]   nxt_idx,
  input  wr_phase_e          nxt_phase,
  input  logic               seq_end,
  output logic               busy,
  output logic               done,
  output logic [NUM_MODS-1:0] disp_wr_n,
  output logic [ADDR_W-1:0]  disp_addr,
  output logic [6:0]         disp_char
);

  localparam int NUM_CHARS = NUM_MODS * DIGITS_PER_MOD;

  logic [VALUE_W-1:0] val_q;
  logic [VALUE_W-1:0] val_d;
  logic [3:0]         nib;
  int                 nxt_mod;

  always_comb begin
    val_d   = start ? start_value : val_q;
    nib     = val_d[(NUM_CHARS - 1 - int'(nxt_idx)) * 4 +: 4];
    nxt_mod = int'(nxt_idx) / DIGITS_PER_MOD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      disp_addr <= '0;
      disp_char <= 7'h20;
    end else begin
      val_q <= val_d;
      busy  <= nxt_active;
      done  <= seq_end;
      if (nxt_active) begin
        disp_addr <= ADDR_W'(int'(nxt_idx) % DIGITS_PER_MOD);
        disp_char <= nib_to_ascii(nib);
      end
    end
  end

  // One strobe register per module
  for (genvar m = 0; m < NUM_MODS; m++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (rst) disp_wr_n[m] <= 1'b1;
      else     disp_wr_n[m] <= !(nxt_active && (nxt_phase == PH_STROBE) && (nxt_mod == m));
    end
  end

endmodule

// File: rtl/hexdisp_writer.sv
`timescale 1ns/1ps
module hexdisp_writer
  import hexdisp_pkg::*;
#(
  parameter int NUM_MODS       = 2,
  parameter int DIGITS_PER_MOD = 4,
  parameter int SETUP_CYC      = 1,
  parameter int STROBE_CYC     = 2,
  parameter int HOLD_CYC       = 1
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  upd_req,
  input  logic [4*NUM_MODS*DIGITS_PER_MOD-1:0]  upd_value,
  output logic                                  busy,
  output logic                                  done,
  output logic [NUM_MODS-1:0]                   disp_wr_n,
  output logic [$clog2(DIGITS_PER_MOD)-1:0]     disp_addr,
  output logic [6:0]                            disp_char
);

  localparam int NUM_CHARS = NUM_MODS * DIGITS_PER_MOD;
  localparam int VALUE_W   = 4 * NUM_CHARS;
  localparam int IDX_W     = $clog2(NUM_CHARS);
  localparam int ADDR_W    = $clog2(DIGITS_PER_MOD);

  logic               start;
  logic [VALUE_W-1:0] start_value;
  logic               active;
  logic               seq_end;
  logic               nxt_active;
  logic [IDX_W-1:0]   nxt_idx;
  wr_phase_e          nxt_phase;

  hexdisp_req_latch #(.VALUE_W(VALUE_W)) u_req (
    .clk         (clk),
    .rst         (rst),
    .upd_req     (upd_req),
    .upd_value   (upd_value),
    .active      (active),
    .seq_end     (seq_end),
    .start       (start),
    .start_value (start_value)
  );

  hexdisp_sequencer #(
    .NUM_CHARS  (NUM_CHARS),
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .IDX_W      (IDX_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .active     (active),
    .seq_end    (seq_end),
    .nxt_active (nxt_active),
    .nxt_idx    (nxt_idx),
    .nxt_phase  (nxt_phase)
  );

  hexdisp_outreg #(
    .NUM_MODS       (NUM_MODS),
    .DIGITS_PER_MOD (DIGITS_PER_MOD),
    .IDX_W          (IDX_W),
    .ADDR_W         (ADDR_W),
    .VALUE_W        (VALUE_W)
  ) u_out (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_value (start_value),
    .nxt_active  (nxt_active),
    .nxt_idx     (nxt_idx),
    .nxt_phase   (nxt_phase),
    .seq_end     (seq_end),
    .busy        (busy),
    .done        (done),
    .disp_wr_n   (disp_wr_n),
    .disp_addr   (disp_addr),
    .disp_char   (disp_char)
  );

endmodule

// File: rtl/hexdisp_writer_chk.sv
`timescale 1ns/1ps
module hexdisp_writer_chk #(
  parameter int NUM_MODS   = 2,
  parameter int ADDR_W     = 2,
  parameter int STROBE_CYC = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                busy,
  input logic                done,
  input logic [NUM_MODS-1:0] disp_wr_n,
  input logic [ADDR_W-1:0]   disp_addr,
  input logic [6:0]          disp_char
);

  // R1: no strobe while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (&disp_wr_n));

  // R4: never two modules strobed together
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
    $countones(~disp_wr_n) <= 1);

  // R4: position and code steady while a strobe is low
  a_r4_bus_stable: assert property (@(posedge clk) disable iff (rst)
    (!(&disp_wr_n)) |-> ($stable(disp_addr) && $stable(disp_char)));

  // R4: after a strobe is released the bus stays quiet for a cycle
  a_r4_release_gap: assert property (@(posedge clk) disable iff (rst)
    ((&disp_wr_n) && !$past(&disp_wr_n)) |=> (&disp_wr_n));

  // R4: a strobe lasts at least two cycles when configured so
  if (STROBE_CYC >= 2) begin : g_len
    a_r4_strobe_len: assert property (@(posedge clk) disable iff (rst)
      ((!(&disp_wr_n)) && $past(&disp_wr_n)) |=> (disp_wr_n == $past(disp_wr_n)));
  end

  // R2: only hex digit codes are strobed
  a_r2_hex_code: assert property (@(posedge clk) disable iff (rst)
    (!(&disp_wr_n)) |-> (((disp_char >= 7'h30) && (disp_char <= 7'h39)) ||
                         ((disp_char >= 7'h41) && (disp_char <= 7'h46))));

  // R7: done is a single-cycle pulse following a busy cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

endmodule

bind hexdisp_writer hexdisp_writer_chk #(
  .NUM_MODS   (NUM_MODS),
  .ADDR_W     (ADDR_W),
  .STROBE_CYC (STROBE_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .disp_wr_n (disp_wr_n),
  .disp_addr (disp_addr),
  .disp_char (disp_char)
);

// File: tb/tb_hexdisp_writer.sv
`timescale 1ns/1ps
module tb_hexdisp_writer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_req = 1'b0;
  logic [31:0] upd_value = '0;
  logic        busy;
  logic        done;
  logic [1:0]  disp_wr_n;
  logic [1:0]  disp_addr;
  logic [6:0]  disp_char;

  always #2.5 clk = ~clk;

  hexdisp_writer dut (
    .clk       (clk),
    .rst       (rst),
    .upd_req   (upd_req),
    .upd_value (upd_value),
    .busy      (busy),
    .done      (done),
    .disp_wr_n (disp_wr_n),
    .disp_addr (disp_addr),
    .disp_char (disp_char)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Behavioural reference state
  bit          m_active;
  int          m_cyc;
  logic [31:0] m_val;
  bit          m_pend;
  logic [31:0] m_pval;
  bit          m_done;
  int          done_seen;

  // Model of the two display modules
  logic [6:0] dmem [2][4];
  logic [1:0] prev_wr = 2'b11;

  function automatic logic [6:0] exp_code(input logic [31:0] v, input int k);
    int n;
    n = int'((v >> (4 * (7 - k))) & 32'hF);
    if (n < 10) return 7'(8'h30 + n);
    return 7'(8'h41 + n - 10);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_start(input logic [31:0] v);
    m_active = 1; m_cyc = 0; m_val = v;
  endtask

  task automatic model_step(input bit r, input logic [31:0] v);
    m_done = 0;
    if (rst) begin
      m_active = 0; m_pend = 0; m_cyc = 0;
    end else if (m_active) begin
      if (m_cyc == 31) begin
        m_done = 1;
        if (r) begin model_start(v); m_pend = 0; end
        else if (m_pend) begin model_start(m_pval); m_pend = 0; end
        else m_active = 0;
      end else begin
        m_cyc++;
        if (r) begin m_pend = 1; m_pval = v; end
      end
    end else if (r) begin
      model_start(v);
    end
  endtask

  task automatic compare();
    int k, ph;
    k  = m_cyc / 4;
    ph = m_cyc % 4;
    check(busy == m_active, "R5", "busy", 32'(busy), 32'(m_active));
    check(done == m_done, "R7", "done", 32'(done), 32'(m_done));
    if (m_done) done_seen++;
    for (int m = 0; m < 2; m++) begin
      bit low;
      low = m_active && (ph == 1 || ph == 2) && (m == k / 4);
      check(disp_wr_n[m] == !low, "R4", $sformatf("strobe %0d", m),
            32'(disp_wr_n[m]), 32'(!low));
    end
    if (m_active) begin
      check(disp_addr == 2'(k % 4), "R3", "position", 32'(disp_addr), 32'(k % 4));
      check(disp_char == exp_code(m_val, k), "R2", "code",
            32'(disp_char), 32'(exp_code(m_val, k)));
    end
    for (int m = 0; m < 2; m++)
      if (prev_wr[m] == 1'b0 && disp_wr_n[m] == 1'b1) dmem[m][disp_addr] = disp_char;
    prev_wr = disp_wr_n;
  endtask

  task automatic tick(input bit r, input logic [31:0] v);
    upd_req   = r;
    upd_value = v;
    @(posedge clk);
    @(negedge clk);
    model_step(r, v);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 32'hDEAD_0000 + 32'(i));
  endtask

  task automatic check_display(input logic [31:0] v, input string req);
    for (int k = 0; k < 8; k++)
      check(dmem[k / 4][k % 4] == exp_code(v, k), req,
            $sformatf("stored char %0d", k),
            32'(dmem[k / 4][k % 4]), 32'(exp_code(v, k)));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 4; a++) dmem[m][a] = 7'h00;
    m_active = 0; m_pend = 0; m_cyc = 0; m_done = 0; done_seen = 0;

    // R1: reset state
    rst = 1'b1;
    for (int i = 0; i < 3; i++) tick(1'b1, 32'h1234_5678);
    rst = 1'b0;
    tick(1'b0, '0);
    check(busy == 1'b0, "R1", "busy after reset", 32'(busy), 0);
    check(disp_wr_n == 2'b11, "R1", "strobes after reset", 32'(disp_wr_n), 3);
    check(done == 1'b0, "R1", "done after reset", 32'(done), 0);

    // R5, R3: basic sequence, digits 0..7
    tick(1'b1, 32'h0123_4567);
    idle(40);
    check_display(32'h0123_4567, "R3");

    // R8: value wiggles during a sequence without a request
    tick(1'b1, 32'h89AB_CDEF);
    for (int i = 0; i < 40; i++) tick(1'b0, 32'h5555_0000 ^ 32'(i * 7));
    check_display(32'h89AB_CDEF, "R2");

    // R8: idle with changing value and no request: nothing written
    for (int i = 0; i < 20; i++) tick(1'b0, 32'hFFFF_FFFF - 32'(i));
    check_display(32'h89AB_CDEF, "R8");

    // R6: two requests during busy collapse into one, newest wins
    done_seen = 0;
    tick(1'b1, 32'hFEDC_BA98);
    idle(4);
    tick(1'b1, 32'h1111_1111);
    idle(5);
    tick(1'b1, 32'h2468_ACE0);
    idle(70);
    check(done_seen == 2, "R6", "sequences run", 32'(done_seen), 2);
    check_display(32'h2468_ACE0, "R6");

    // R6: request lands exactly on the last hold cycle
    done_seen = 0;
    tick(1'b1, 32'hA5A5_0F0F);
    idle(31);
    tick(1'b1, 32'hFFFF_FFFF);
    check(busy == 1'b1, "R6", "busy across restart", 32'(busy), 1);
    idle(40);
    check(done_seen == 2, "R7", "done pulses", 32'(done_seen), 2);
    check_display(32'hFFFF_FFFF, "R6");

    // R2: all zeros
    tick(1'b1, 32'h0000_0000);
    idle(40);
    check_display(32'h0000_0000, "R2");

    finish_run();
  end

endmodule